// File: doc/BRIEF.md
# Microcontroller Data and Code Space Router

This block is the on-chip memory subsystem of a small 8-bit microcontroller. Each CPU data access names an address, an addressing kind (direct, indirect or external-move) and a direction. From these, and from one configuration bit that moves the expanded RAM off-chip, the block picks one of five targets and serves the access. The five targets are the low scratch RAM, the high RAM, the special-register bus, the on-chip expanded RAM and the external data bus. The three RAM arrays sit inside the block. The special-register bus and the external bus are ports that connect to logic outside it.

The bytes at 80H-FFH exist twice. The addressing kind alone decides between them: a direct access reaches a special register, and an indirect access reaches the high RAM. Stack pushes and pops are indirect, so a stack placed above 7FH lives in the high RAM. The block also classifies each instruction fetch as internal or external code memory, based on the external-access pin and the fetch address.

A request is a one-cycle pulse on `req_i`. Accesses to internal targets complete in one cycle. External accesses hold a bus request until the bus acknowledges, and the CPU issues no new request until `ready_o` has pulsed.

Top module: `mcu_mem_router`

## Requirements
- R1: An access with kind direct (`acc_i`=00) or indirect (`acc_i`=01) to 00H-7FH uses the 128-byte low RAM. Both kinds reach the same bytes.
- R2: A direct access to 80H-FFH raises `sfr_req_o` in the same cycle, with the address, write flag and write data passed through. A read returns the `sfr_rdata_i` sampled at that edge. No RAM is touched.
- R3: An indirect access to 80H-FFH uses a 128-byte high RAM that is separate from the special registers. `sfr_req_o` stays low. Stack operations are indirect accesses and follow this rule.
- R4: An external-move access (`acc_i`=10) with the expanded-RAM-off bit clear and address 0000H-00FFH uses the 256-byte on-chip expanded RAM. `xbus_req_o` stays low.
- R5: An external-move access with the expanded-RAM-off bit set, or with address 0100H or above, raises `xbus_req_o` from the cycle after the request until the cycle of `xbus_ack_i`. Address, write flag and data are held during that time. The read data is `xbus_rdata_i` at the acknowledge.
- R6: `ready_o` pulses for one cycle. For an internal access it comes one cycle after the request, and for an external access one cycle after the acknowledge. Read data is valid on `rdata_o` while `ready_o` is high.
- R7: In a request cycle `sel_o` is one-hot: bit0 low RAM, bit1 high RAM, bit2 special registers, bit3 expanded RAM, bit4 external bus. `sel_o` is zero when there is no request.
- R8: Reset clears the expanded-RAM-off bit. `cfg_we_i` loads it from `cfg_extram_i`. While the bit is set, expanded RAM contents are unaffected by external-move accesses.
- R9: With `ea_i` low, every fetch (`fetch_req_i` high) raises `code_ext_o` and never `code_int_o`.
- R10: With `ea_i` high, a fetch below 8000H raises `code_int_o` and a fetch at 8000H or above raises `code_ext_o`. Both outputs are low without a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the expanded-RAM-off bit |
| cfg_extram_i | input | 1 | New value of the expanded-RAM-off bit |
| req_i | input | 1 | Data access request pulse |
| acc_i | input | 2 | Access kind: 00 direct, 01 indirect, 10 external-move |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 16 | Access address (low 8 bits for direct and indirect) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with ready_o |
| ready_o | output | 1 | Access complete |
| sel_o | output | 5 | One-hot target of the current request |
| sfr_req_o | output | 1 | Special-register bus request |
| sfr_we_o | output | 1 | Special-register write |
| sfr_addr_o | output | 8 | Special-register address |
| sfr_wdata_o | output | 8 | Special-register write data |
| sfr_rdata_i | input | 8 | Special-register read data |
| xbus_req_o | output | 1 | External bus request, held until ack |
| xbus_we_o | output | 1 | External bus write |
| xbus_addr_o | output | 16 | External bus address |
| xbus_wdata_o | output | 8 | External bus write data |
| xbus_rdata_i | input | 8 | External bus read data |
| xbus_ack_i | input | 1 | External bus acknowledge |
| fetch_req_i | input | 1 | Instruction fetch |
| fetch_addr_i | input | 16 | Fetch address |
| ea_i | input | 1 | External-access pin |
| code_int_o | output | 1 | Fetch served by internal code memory |
| code_ext_o | output | 1 | Fetch served externally |

## Verification
The same byte addresses are accessed with each addressing kind. Writing A0H indirectly and then reading it directly while the special-register bus returns a different byte separates the high RAM from the register space. Writing a low address directly and reading it back indirectly shows that the low RAM is shared. External-move accesses at 0020H, 00FFH, 0100H and 1234H, with the expanded-RAM-off bit in both states, and with zero and several wait cycles, separate the on-chip expanded RAM from the bus and show that the on-chip copy survives while the bit is set. Fetches at 0000H, 7FFFH and 8000H, with the pin in both states, locate the code boundary.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;
  localparam logic [1:0] ACC_DIRECT   = 2'b00;
  localparam logic [1:0] ACC_INDIRECT = 2'b01;
  localparam logic [1:0] ACC_XMOVE    = 2'b10;

  localparam int NUM_TGT  = 5;
  localparam int TGT_LOW  = 0;
  localparam int TGT_HIGH = 1;
  localparam int TGT_SFR  = 2;
  localparam int TGT_ERAM = 3;
  localparam int TGT_EXT  = 4;
endpackage

// File: rtl/mem_router_ram.sv
module mem_router_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      q_o <= mem[addr_i];
    end
  end
endmodule

// File: rtl/mem_router_decode.sv
module mem_router_decode
  import mem_router_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DIR_AW  = 8,
  parameter int ERAM_AW = 8
) (
  input  logic [1:0]        acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              extram_i,
  output logic [NUM_TGT-1:0] sel_o
);
  logic hi_half;
  logic in_eram;

  assign hi_half = addr_i[DIR_AW-1];
  assign in_eram = (addr_i[ADDR_W-1:ERAM_AW] == '0);

  always_comb begin
    sel_o = '0;
    unique case (acc_i)
      ACC_XMOVE: begin
        if (!extram_i && in_eram) sel_o[TGT_ERAM] = 1'b1;
        else                      sel_o[TGT_EXT]  = 1'b1;
      end
      ACC_INDIRECT: begin
        if (hi_half) sel_o[TGT_HIGH] = 1'b1;
        else         sel_o[TGT_LOW]  = 1'b1;
      end
      default: begin
        if (hi_half) sel_o[TGT_SFR] = 1'b1;
        else         sel_o[TGT_LOW] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/mem_router_fetch.sv
module mem_router_fetch #(
  parameter int ADDR_W    = 16,
  parameter int CODE_SIZE = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              ea_i,
  output logic              code_int_o,
  output logic              code_ext_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(CODE_SIZE);

  logic below;
  assign below      = ({1'b0, fetch_addr_i} < LIMIT);
  assign code_int_o = fetch_req_i & ea_i & below;
  assign code_ext_o = fetch_req_i & ~(ea_i & below);

  // R9: pin low never selects internal code
  a_r9_ea_low_external: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !ea_i) |-> (code_ext_o && !code_int_o));
  // R10: exactly one code target per fetch, none otherwise
  a_r10_code_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i ? $onehot({code_int_o, code_ext_o}) : !(code_int_o || code_ext_o));
endmodule

// File: rtl/mcu_mem_router.sv
module mcu_mem_router
  import mem_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int LOW_DEPTH  = 128,
  parameter int ERAM_DEPTH = 256,
  parameter int CODE_SIZE  = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_extram_i,
  input  logic              req_i,
  input  logic [1:0]        acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic [4:0]        sel_o,
  output logic              sfr_req_o,
  output logic              sfr_we_o,
  output logic [7:0]        sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic              xbus_req_o,
  output logic              xbus_we_o,
  output logic [ADDR_W-1:0] xbus_addr_o,
  output logic [DATA_W-1:0] xbus_wdata_o,
  input  logic [DATA_W-1:0] xbus_rdata_i,
  input  logic              xbus_ack_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              ea_i,
  output logic              code_int_o,
  output logic              code_ext_o
);
  localparam int LOW_AW  = $clog2(LOW_DEPTH);
  localparam int DIR_AW  = LOW_AW + 1;
  localparam int ERAM_AW = $clog2(ERAM_DEPTH);

  logic               extram_q;
  logic               pend_q;
  logic               accept;
  logic [NUM_TGT-1:0] tgt;
  logic [NUM_TGT-1:0] rsel_q;
  logic               rdy_q;
  logic [DATA_W-1:0]  hold_q;
  logic [DATA_W-1:0]  low_q, high_q, eram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       extram_q <= 1'b0;
    else if (cfg_we_i) extram_q <= cfg_extram_i;
  end

  mem_router_decode #(.ADDR_W(ADDR_W), .DIR_AW(DIR_AW), .ERAM_AW(ERAM_AW)) u_decode (
    .acc_i(acc_i), .addr_i(addr_i), .extram_i(extram_q), .sel_o(tgt)
  );

  assign accept = req_i & ~pend_q;
  assign sel_o  = accept ? tgt : '0;

  mem_router_ram #(.DEPTH(LOW_DEPTH), .DATA_W(DATA_W)) u_low (
    .clk_i(clk_i), .en_i(sel_o[TGT_LOW]), .we_i(we_i),
    .addr_i(addr_i[LOW_AW-1:0]), .wdata_i(wdata_i), .q_o(low_q)
  );
  mem_router_ram #(.DEPTH(LOW_DEPTH), .DATA_W(DATA_W)) u_high (
    .clk_i(clk_i), .en_i(sel_o[TGT_HIGH]), .we_i(we_i),
    .addr_i(addr_i[LOW_AW-1:0]), .wdata_i(wdata_i), .q_o(high_q)
  );
  mem_router_ram #(.DEPTH(ERAM_DEPTH), .DATA_W(DATA_W)) u_eram (
    .clk_i(clk_i), .en_i(sel_o[TGT_ERAM]), .we_i(we_i),
    .addr_i(addr_i[ERAM_AW-1:0]), .wdata_i(wdata_i), .q_o(eram_q)
  );

  assign sfr_req_o   = sel_o[TGT_SFR];
  assign sfr_we_o    = we_i;
  assign sfr_addr_o  = addr_i[7:0];
  assign sfr_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      xbus_we_o    <= 1'b0;
      xbus_addr_o  <= '0;
      xbus_wdata_o <= '0;
    end else if (sel_o[TGT_EXT]) begin
      pend_q       <= 1'b1;
      xbus_we_o    <= we_i;
      xbus_addr_o  <= addr_i;
      xbus_wdata_o <= wdata_i;
    end else if (pend_q && xbus_ack_i) begin
      pend_q <= 1'b0;
    end
  end
  assign xbus_req_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      rsel_q <= '0;
      hold_q <= '0;
    end else begin
      rdy_q <= (accept & ~tgt[TGT_EXT]) | (pend_q & xbus_ack_i);
      if (accept) rsel_q <= tgt;
      if (sel_o[TGT_SFR])           hold_q <= sfr_rdata_i;
      else if (pend_q && xbus_ack_i) hold_q <= xbus_rdata_i;
    end
  end
  assign ready_o = rdy_q;

  always_comb begin
    if (rsel_q[TGT_LOW])       rdata_o = low_q;
    else if (rsel_q[TGT_HIGH]) rdata_o = high_q;
    else if (rsel_q[TGT_ERAM]) rdata_o = eram_q;
    else                       rdata_o = hold_q;
  end

  mem_router_fetch #(.ADDR_W(ADDR_W), .CODE_SIZE(CODE_SIZE)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_req_i(fetch_req_i),
    .fetch_addr_i(fetch_addr_i), .ea_i(ea_i),
    .code_int_o(code_int_o), .code_ext_o(code_ext_o)
  );

  // R7: one target per accepted request
  a_r7_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xbus_req_o) |-> ($countones(sel_o) == 1));
  // R2: register bus reached only by direct accesses to the upper half
  a_r2_sfr_direct_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_req_o |-> (acc_i == ACC_DIRECT && addr_i[7]));
  // R5: bus request held with stable address until acknowledged
  a_r5_xbus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xbus_req_o && !xbus_ack_i) |=> (xbus_req_o && $stable(xbus_addr_o)));
  // R6: internal access completes in the next cycle
  a_r6_ready_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xbus_req_o && !sel_o[TGT_EXT]) |=> ready_o);
  // R6: ready is a single-cycle pulse
  a_r6_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: tb/mcu_mem_router_bench.sv
`timescale 1ns/1ps
module mcu_mem_router_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_x = 0, req = 0, we = 0;
  logic [1:0] acc = 0;
  logic [15:0] addr = 0;
  logic [7:0] wd = 0, sfr_rd = 0, x_rd = 0;
  logic x_ack = 0, f_req = 0, ea = 0;
  logic [15:0] f_addr = 0;
  logic [7:0] rdata, sfr_addr, sfr_wd, x_wd;
  logic ready, sfr_req, sfr_we, x_req, x_we, c_int, c_ext;
  logic [4:0] sel;
  logic [15:0] x_addr;

  int checks = 0, fails = 0;
  bit exp_busy = 0;
  bit m_extram = 0;
  byte unsigned m_low [128];
  byte unsigned m_high[128];
  byte unsigned m_eram[256];

  always #2.5 clk = ~clk;

  mcu_mem_router u_mcu_mem_router (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_extram_i(cfg_x),
    .req_i(req), .acc_i(acc), .we_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .ready_o(ready), .sel_o(sel),
    .sfr_req_o(sfr_req), .sfr_we_o(sfr_we), .sfr_addr_o(sfr_addr),
    .sfr_wdata_o(sfr_wd), .sfr_rdata_i(sfr_rd),
    .xbus_req_o(x_req), .xbus_we_o(x_we), .xbus_addr_o(x_addr),
    .xbus_wdata_o(x_wd), .xbus_rdata_i(x_rd), .xbus_ack_i(x_ack),
    .fetch_req_i(f_req), .fetch_addr_i(f_addr), .ea_i(ea),
    .code_int_o(c_int), .code_ext_o(c_ext)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // target index: 0 low, 1 high, 2 sfr, 3 eram, 4 ext
  function automatic int tgt_of(input logic [1:0] k, input logic [15:0] a);
    if (k == 2'b10) return (!m_extram && a < 16'h0100) ? 3 : 4;
    if (a[7:0] < 8'h80) return 0;
    return (k == 2'b01) ? 1 : 2;
  endfunction

  // per-cycle reference comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [4:0] es;
      es = (req && !exp_busy) ? 5'(1 << tgt_of(acc, addr)) : 5'b0;
      chk(sel == es, "R7 sel", sel, es);
      chk(x_req == exp_busy, "R5 xbus_req", x_req, exp_busy);
      chk(sfr_req == es[2], "R2 sfr_req", sfr_req, es[2]);
      chk(c_int == (f_req && ea && f_addr < 16'h8000), "R10 code_int", c_int,
          f_req && ea && f_addr < 16'h8000);
      chk(c_ext == (f_req && !(ea && f_addr < 16'h8000)), "R9 code_ext", c_ext,
          f_req && !(ea && f_addr < 16'h8000));
    end
  end

  task automatic access(input logic [1:0] k, input logic [15:0] a, input bit w,
                        input byte unsigned d, input byte unsigned srd,
                        input int waits, input byte unsigned xrd, input string tag);
    int t;
    int exp;
    t = tgt_of(k, a);
    case (t)
      0: exp = m_low[a[6:0]];
      1: exp = m_high[a[6:0]];
      2: exp = srd;
      3: exp = m_eram[a[7:0]];
      default: exp = xrd;
    endcase
    @(negedge clk);
    req = 1; acc = k; addr = a; we = w; wd = d; sfr_rd = srd;
    #1;
    if (t == 2) begin
      chk(sfr_addr == a[7:0] && sfr_we == w && (!w || sfr_wd == d),
          {tag, " sfr bus"}, {sfr_addr, sfr_wd}, {a[7:0], d});
    end
    @(negedge clk);
    req = 0;
    if (t == 4) begin
      exp_busy = 1;
      #0.5;
      chk(x_addr == a && x_we == w && (!w || x_wd == d), {tag, " xbus fields"},
          x_addr, a);
      for (int i = 0; i < waits; i++) begin
        @(negedge clk);
        chk(!ready, {tag, " no early ready"}, ready, 0);
      end
      x_ack = 1; x_rd = xrd;
      @(negedge clk);
      x_ack = 0; exp_busy = 0;
    end
    chk(ready, {tag, " ready R6"}, ready, 1);
    if (!w) chk(rdata == 8'(exp), {tag, " rdata"}, rdata, exp);
    if (w) begin
      case (t)
        0: m_low[a[6:0]] = d;
        1: m_high[a[6:0]] = d;
        3: m_eram[a[7:0]] = d;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(!ready, {tag, " ready pulse R6"}, ready, 0);
  endtask

  task automatic set_extram(input bit v);
    @(negedge clk);
    cfg_we = 1; cfg_x = v;
    @(negedge clk);
    cfg_we = 0; m_extram = v;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!ready && sel == 0 && !x_req, "reset state R6", {ready, sel, x_req}, 0);
    // R8: reset leaves expanded RAM on-chip
    access(2'b10, 16'h0020, 1, 8'h77, 0, 0, 0, "R8 eram after reset");
    // R1
    access(2'b00, 16'h0010, 1, 8'h3C, 0, 0, 0, "R1 direct wr");
    access(2'b01, 16'h0010, 0, 0, 0, 0, 0, "R1 indirect rd");
    access(2'b01, 16'h007F, 1, 8'hA5, 0, 0, 0, "R1 indirect wr");
    access(2'b00, 16'h007F, 0, 0, 0, 0, 0, "R1 direct rd");
    // R3 / R2 separation
    access(2'b01, 16'h00A0, 1, 8'h55, 0, 0, 0, "R3 indirect wr A0");
    access(2'b00, 16'h00A0, 1, 8'h12, 0, 0, 0, "R2 direct wr A0");
    access(2'b00, 16'h00A0, 0, 0, 8'h99, 0, 0, "R2 direct rd A0");
    access(2'b01, 16'h00A0, 0, 0, 8'h99, 0, 0, "R3 indirect rd A0");
    access(2'b01, 16'h00FF, 1, 8'hE7, 0, 0, 0, "R3 stack top wr");
    access(2'b01, 16'h00FF, 0, 0, 0, 0, 0, "R3 stack top rd");
    access(2'b00, 16'h0080, 0, 0, 8'h4D, 0, 0, "R2 direct rd 80");
    // R4
    access(2'b10, 16'h0020, 0, 0, 0, 0, 0, "R4 eram rd");
    access(2'b10, 16'h00FF, 1, 8'hB2, 0, 0, 0, "R4 eram top wr");
    access(2'b10, 16'h00FF, 0, 0, 0, 0, 0, "R4 eram top rd");
    // R5
    access(2'b10, 16'h0100, 0, 0, 0, 3, 8'hE1, "R5 ext rd 0100");
    access(2'b10, 16'h1234, 1, 8'h6A, 0, 0, 0, "R5 ext wr 1234");
    access(2'b10, 16'hFFFF, 0, 0, 0, 1, 8'h0F, "R5 ext rd FFFF");
    // R8: bit set diverts low external space, on-chip copy kept
    set_extram(1);
    access(2'b10, 16'h0020, 1, 8'hC3, 0, 2, 0, "R8 ext wr 0020");
    access(2'b10, 16'h0020, 0, 0, 0, 0, 8'h5A, "R8 ext rd 0020");
    set_extram(0);
    access(2'b10, 16'h0020, 0, 0, 0, 0, 0, "R8 eram kept");
    // R9 / R10 fetch boundary
    @(negedge clk); f_req = 1; ea = 0; f_addr = 16'h0000;
    #1 chk(c_ext && !c_int, "R9 ea low 0000", {c_int, c_ext}, 1);
    @(negedge clk); ea = 1; f_addr = 16'h7FFF;
    #1 chk(c_int && !c_ext, "R10 7FFF internal", {c_int, c_ext}, 2);
    @(negedge clk); f_addr = 16'h8000;
    #1 chk(c_ext && !c_int, "R10 8000 external", {c_int, c_ext}, 1);
    @(negedge clk); f_req = 0;
    #1 chk(!c_ext && !c_int, "R10 no fetch", {c_int, c_ext}, 0);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule